// File: doc/BRIEF.md
# Remote Register Bus Access over UDP

This block serves register read and write requests that a host sends inside UDP datagrams. It receives the datagram payload as a byte stream, already filtered by port, and parses an eight-byte header followed, for writes, by the data bytes. It then performs the burst on a byte-wide synchronous register bus. One byte moves per access, and the address steps by one after each access.

When the burst ends, the block builds an acknowledgement payload. It raises a transmit request towards an arbiter and streams the reply only after it receives a grant. The reply echoes the request ID, reports how many bytes were actually transferred, and carries the read data or the written data. A per-access timer cuts short a burst whose target never answers and marks the reply with an error bit.

The block holds one request at a time in a single data buffer. Any packet that starts while a request is in progress is discarded completely, including the bytes that arrive after the block becomes free again.

Top module: `rbus_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, `tx_req`, `tx_valid`, `bus_we` and `bus_re` are low.
- R2: The request header is byte 0 = 0xFF (format code), byte 1 = command, byte 2 = ID, byte 3 = length in bytes, bytes 4..7 = a big-endian 32-bit start address. In the command byte, bit 6 requests a read, bit 5 requests a write and bit 7 marks an acknowledgement. A read request with a correct header is carried out in full.
- R3: During a burst, access k drives `bus_addr` = start address + k (modulo 2^32). Only one of `bus_re` and `bus_we` is high. Address and strobe stay fixed until `bus_ack` is seen or the access times out, and no strobe is high outside a burst.
- R4: A write request drives payload byte k on `bus_wdata` during access k.
- R5: The reply is byte 0 = 0xFF, byte 1 = 0x80 | (0x40 for read or 0x20 for write) | error bit 0, byte 2 = request ID, byte 3 = bytes transferred, bytes 4..7 = start address (big-endian). These are followed by one data byte per transferred byte: the read data or the written data. `tx_last` marks the final byte.
- R6: If an access sees no `bus_ack` for TIMEOUT consecutive cycles, the burst stops. The reply then reports only the bytes completed before that access and has bit 0 of byte 1 set.
- R7: No bus access and no reply result from any of the following: a wrong format byte, acknowledgement bit set, both or neither of the read/write bits set, a length of 0, a length above DEPTH, a packet shorter than 8 bytes, or a write carrying fewer data bytes than its length.
- R8: A packet whose first byte arrives while a request is in progress is discarded completely, with no bus access and no reply. The next packet after it is served normally.
- R9: `tx_req` stays high until `tx_grant`. `tx_valid` rises only in the cycle after `tx_req` and `tx_grant` were both high, and the reply bytes then follow on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Request payload byte valid |
| rx_data | input | 8 | Request payload byte |
| rx_last | input | 1 | Final byte of the request payload |
| bus_addr | output | 32 | Register bus address |
| bus_we | output | 1 | Write strobe, held until acknowledge or timeout |
| bus_re | output | 1 | Read strobe, held until acknowledge or timeout |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled with `bus_ack` |
| bus_ack | input | 1 | Target completes the current access |
| tx_req | output | 1 | Request to transmit a reply |
| tx_grant | input | 1 | Arbiter grants the transmit request |
| tx_valid | output | 1 | Reply byte valid |
| tx_data | output | 8 | Reply byte |
| tx_last | output | 1 | Final reply byte |

## Verification
The properties assume that the arbiter raises `tx_grant` only while `tx_req` is high and that the target drives `bus_ack` only while a strobe is high. The bench's grant driver pulses the grant for one cycle after it sees the request, and the target model acknowledges only strobed cycles. The bench also assumes that the sink accepts a reply byte every cycle. Request bytes are sent back to back with `rx_last` on exactly the final byte. Every packet is started only once the previous reply has finished, except in the deliberate busy-drop case.

// File: rtl/rbus_pkg.sv
package rbus_pkg;

    typedef enum logic [1:0] {
        PH_RX  = 2'd0,
        PH_BUS = 2'd1,
        PH_REQ = 2'd2,
        PH_TX  = 2'd3
    } phase_e;

    localparam int         HDR_BYTES = 8;
    localparam logic [7:0] FMT_CODE  = 8'hFF;
    localparam int         CB_ACK    = 7;
    localparam int         CB_RD     = 6;
    localparam int         CB_WR     = 5;
    localparam int         CB_ERR    = 0;

endpackage

// File: rtl/rbus_buf.sv
module rbus_buf #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/rbus_timer.sv
module rbus_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != TW'(LIMIT - 1)) begin
            cnt_d = cnt_q + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == TW'(LIMIT - 1));

endmodule

// File: rtl/rbus_reply_fmt.sv
module rbus_reply_fmt
    import rbus_pkg::*;
#(
    parameter int TXW = 5
) (
    input  logic [TXW-1:0] pos,
    input  logic           is_rd,
    input  logic           is_wr,
    input  logic           err,
    input  logic [7:0]     id,
    input  logic [7:0]     count,
    input  logic [31:0]    addr,
    input  logic [7:0]     payload,
    output logic [7:0]     byte_out
);

    logic [7:0] cmd_byte;

    always_comb begin
        cmd_byte         = 8'h00;
        cmd_byte[CB_ACK] = 1'b1;
        cmd_byte[CB_RD]  = is_rd;
        cmd_byte[CB_WR]  = is_wr;
        cmd_byte[CB_ERR] = err;
    end

    always_comb begin
        case (pos)
            TXW'(0): byte_out = FMT_CODE;
            TXW'(1): byte_out = cmd_byte;
            TXW'(2): byte_out = id;
            TXW'(3): byte_out = count;
            TXW'(4): byte_out = addr[31:24];
            TXW'(5): byte_out = addr[23:16];
            TXW'(6): byte_out = addr[15:8];
            TXW'(7): byte_out = addr[7:0];
            default: byte_out = payload;
        endcase
    end

endmodule

// File: rtl/rbus_ctrl.sv
module rbus_ctrl
    import rbus_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int TIMEOUT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic [31:0] bus_addr,
    output logic        bus_we,
    output logic        bus_re,
    output logic [7:0]  bus_wdata,
    input  logic [7:0]  bus_rdata,
    input  logic        bus_ack,
    output logic        tx_req,
    input  logic        tx_grant,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last
);

    localparam int         AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int         TXW     = $clog2(DEPTH + HDR_BYTES + 1);
    localparam logic [7:0] LEN_MAX = 8'(DEPTH);

    typedef struct packed {
        phase_e         st;
        logic           open;
        logic           cap;
        logic [15:0]    cnt;
        logic           fmt_ok;
        logic           ack_bit;
        logic           is_rd;
        logic           is_wr;
        logic [7:0]     id;
        logic [7:0]     len;
        logic [31:0]    addr;
        logic [7:0]     idx;
        logic           err;
        logic [TXW-1:0] txi;
    } regs_t;

    regs_t d, q;

    logic          buf_we;
    logic [AW-1:0] buf_waddr;
    logic [7:0]    buf_wdata;
    logic [7:0]    buf_rd_a;
    logic [7:0]    buf_rd_b;
    logic [15:0]   cur;
    logic [15:0]   total;
    logic          take;
    logic          hdr_ok;
    logic          strobe;
    logic          tmo;
    logic          tx_end;

    // byte position within the arriving packet, and whether it is captured
    assign cur   = q.open ? q.cnt : 16'd0;
    assign total = cur + 16'd1;
    assign take  = q.open ? q.cap : (q.st == PH_RX);

    assign hdr_ok = (total >= 16'(HDR_BYTES)) && q.fmt_ok && !q.ack_bit
                 && (q.is_rd ^ q.is_wr) && (q.len != 8'd0) && (q.len <= LEN_MAX)
                 && (!q.is_wr || (total >= 16'(HDR_BYTES) + 16'(q.len)));

    assign strobe = (q.st == PH_BUS);
    assign tx_end = (16'(q.txi) == 16'(HDR_BYTES - 1) + 16'(q.idx));

    always_comb begin
        d         = q;
        buf_we    = 1'b0;
        buf_waddr = '0;
        buf_wdata = 8'h00;

        if (rx_valid) begin
            d.open = !rx_last;
            d.cap  = take && !rx_last;
            d.cnt  = (cur == 16'hFFFF) ? cur : total;
            if (take) begin
                case (cur)
                    16'd0: d.fmt_ok = (rx_data == FMT_CODE);
                    16'd1: begin
                        d.ack_bit = rx_data[CB_ACK];
                        d.is_rd   = rx_data[CB_RD];
                        d.is_wr   = rx_data[CB_WR];
                    end
                    16'd2: d.id  = rx_data;
                    16'd3: d.len = rx_data;
                    16'd4, 16'd5, 16'd6, 16'd7: d.addr = {q.addr[23:0], rx_data};
                    default: begin
                        if (cur < 16'(HDR_BYTES + DEPTH)) begin
                            buf_we    = 1'b1;
                            buf_waddr = AW'(cur - 16'(HDR_BYTES));
                            buf_wdata = rx_data;
                        end
                    end
                endcase
                if (rx_last && hdr_ok) begin
                    d.st  = PH_BUS;
                    d.idx = 8'd0;
                    d.err = 1'b0;
                end
            end
        end

        case (q.st)
            PH_BUS: begin
                if (bus_ack) begin
                    if (q.is_rd) begin
                        buf_we    = 1'b1;
                        buf_waddr = AW'(q.idx);
                        buf_wdata = bus_rdata;
                    end
                    d.idx = q.idx + 8'd1;
                    if (q.idx + 8'd1 == q.len) begin
                        d.st = PH_REQ;
                    end
                end else if (tmo) begin
                    d.err = 1'b1;
                    d.st  = PH_REQ;
                end
            end
            PH_REQ: begin
                if (tx_grant) begin
                    d.st  = PH_TX;
                    d.txi = '0;
                end
            end
            PH_TX: begin
                d.txi = q.txi + TXW'(1);
                if (tx_end) begin
                    d.st = PH_RX;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: PH_RX, default: '0};
        end else begin
            q <= d;
        end
    end

    rbus_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk     (clk),
        .we      (buf_we),
        .waddr   (buf_waddr),
        .wdata   (buf_wdata),
        .raddr_a (AW'(q.idx)),
        .rdata_a (buf_rd_a),
        .raddr_b (AW'(q.txi - TXW'(HDR_BYTES))),
        .rdata_b (buf_rd_b)
    );

    rbus_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (strobe && !bus_ack),
        .expired (tmo)
    );

    rbus_reply_fmt #(.TXW(TXW)) u_fmt (
        .pos      (q.txi),
        .is_rd    (q.is_rd),
        .is_wr    (q.is_wr),
        .err      (q.err),
        .id       (q.id),
        .count    (q.idx),
        .addr     (q.addr),
        .payload  (buf_rd_b),
        .byte_out (tx_data)
    );

    assign bus_addr  = q.addr + 32'(q.idx);
    assign bus_re    = strobe && q.is_rd;
    assign bus_we    = strobe && q.is_wr;
    assign bus_wdata = buf_rd_a;
    assign tx_req    = (q.st == PH_REQ);
    assign tx_valid  = (q.st == PH_TX);
    assign tx_last   = tx_valid && tx_end;

endmodule

// File: rtl/rbus_ctrl_chk.sv
module rbus_ctrl_chk #(
    parameter int TIMEOUT = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] bus_addr,
    input logic        bus_we,
    input logic        bus_re,
    input logic        bus_ack,
    input logic        tx_req,
    input logic        tx_grant,
    input logic        tx_valid,
    input logic        tx_last
);

    localparam int TW = $clog2(TIMEOUT + 1);

    logic [TW-1:0] wait_q;
    logic          stb;

    assign stb = bus_we || bus_re;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (stb && !bus_ack) begin
            if (wait_q != TW'(TIMEOUT)) begin
                wait_q <= wait_q + TW'(1);
            end
        end else begin
            wait_q <= '0;
        end
    end

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    // R3
    access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !bus_ack && (wait_q < TW'(TIMEOUT - 1))) |=>
        ($stable(bus_addr) && $stable(bus_we) && $stable(bus_re)));

    // R6
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> (wait_q < TW'(TIMEOUT)));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_grant) |=> tx_req);

    // R9
    grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(tx_req && tx_grant));

    // R9
    tx_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (!tx_req && !stb));

    // R5
    last_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

endmodule

bind rbus_ctrl rbus_ctrl_chk #(.TIMEOUT(TIMEOUT)) u_rbus_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_ack  (bus_ack),
    .tx_req   (tx_req),
    .tx_grant (tx_grant),
    .tx_valid (tx_valid),
    .tx_last  (tx_last)
);

// File: tb/rbus_ctrl_bench.sv
module rbus_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int TIMEOUT    = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid, rx_last;
    logic [7:0]  rx_data;
    logic [31:0] bus_addr;
    logic        bus_we, bus_re, bus_ack;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        tx_req, tx_grant, tx_valid, tx_last;
    logic [7:0]  tx_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] tmem [256];
    logic [7:0] rmem [256];
    logic [7:0] pk   [300];
    logic [7:0] wd   [256];
    logic [7:0] expb [300];
    logic [7:0] rep  [300];
    int  pk_n, exp_n, rep_n, frames, bus_act;
    bit  rep_done, granted, in_frame;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbus_ctrl #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) u_rbus_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .tx_req(tx_req), .tx_grant(tx_grant),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
    );

    function automatic bit is_dead(input logic [31:0] a);
        return a[7:4] == 4'hE;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // target model: acknowledges after 0..2 cycles, never for low byte 0xE0..0xEF
    initial begin
        int lat;
        int wcnt;
        lat = 0; wcnt = 0;
        bus_ack = 1'b0; bus_rdata = 8'h00;
        forever begin
            @(negedge clk);
            if (bus_re || bus_we) begin
                bus_act++;
                if (!is_dead(bus_addr) && wcnt >= lat) begin
                    bus_ack   = 1'b1;
                    bus_rdata = tmem[bus_addr[7:0]];
                    if (bus_we) tmem[bus_addr[7:0]] = bus_wdata;
                    wcnt = 0;
                    lat  = $urandom_range(0, 2);
                end else begin
                    bus_ack = 1'b0;
                    wcnt++;
                end
            end else begin
                bus_ack = 1'b0;
                wcnt    = 0;
            end
        end
    end

    // arbiter model
    initial begin
        tx_grant = 1'b0;
        forever begin
            @(negedge clk);
            if (tx_req && !tx_grant) begin
                repeat ($urandom_range(0, 4)) @(negedge clk);
                tx_grant = 1'b1;
                granted  = 1'b1;
                @(negedge clk);
                tx_grant = 1'b0;
            end
        end
    end

    // reply collector
    initial begin
        forever begin
            @(negedge clk);
            if (tx_valid) begin
                if (!granted) chk(1'b0, "R9", "byte before grant", 1, 0);
                if (rep_n < 300) rep[rep_n] = tx_data;
                rep_n++;
                in_frame = 1'b1;
                if (tx_last) begin
                    rep_done = 1'b1;
                    frames++;
                    granted  = 1'b0;
                    in_frame = 1'b0;
                end
            end else if (in_frame) begin
                chk(1'b0, "R9", "gap inside reply", 0, 1);
                in_frame = 1'b0;
            end
        end
    end

    task automatic build_req(input bit rd, input logic [7:0] id,
                             input logic [7:0] len, input logic [31:0] a);
        pk[0] = 8'hFF;
        pk[1] = rd ? 8'h40 : 8'h20;
        pk[2] = id;
        pk[3] = len;
        pk[4] = a[31:24]; pk[5] = a[23:16]; pk[6] = a[15:8]; pk[7] = a[7:0];
        pk_n = 8;
        if (!rd) begin
            for (int i = 0; i < int'(len); i++) begin
                wd[i] = 8'($urandom);
                pk[pk_n] = wd[i];
                pk_n++;
            end
        end
    endtask

    task automatic predict(input bit rd, input logic [7:0] id,
                           input logic [7:0] len, input logic [31:0] a);
        int n;
        n = 0;
        while (n < int'(len) && !is_dead(a + 32'(n))) n++;
        expb[0] = 8'hFF;
        expb[1] = {1'b1, rd, !rd, 4'b0000, (n < int'(len))};
        expb[2] = id;
        expb[3] = 8'(n);
        expb[4] = a[31:24]; expb[5] = a[23:16]; expb[6] = a[15:8]; expb[7] = a[7:0];
        for (int i = 0; i < n; i++) begin
            logic [7:0] la;
            la = 8'(a + 32'(i));
            if (rd) begin
                expb[8+i] = rmem[la];
            end else begin
                expb[8+i] = wd[i];
                rmem[la]  = wd[i];
            end
        end
        exp_n = 8 + n;
    endtask

    task automatic send_pkt();
        for (int i = 0; i < pk_n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = pk[i];
            rx_last  = (i == pk_n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic wait_reply();
        for (int i = 0; i < 3000 && !rep_done; i++) @(negedge clk);
    endtask

    task automatic cmp_reply(input string tag);
        int bad;
        bad = -1;
        chk(rep_done && rep_n == exp_n, tag, "reply length", rep_n, exp_n);
        for (int i = 0; i < exp_n && i < rep_n; i++) begin
            if (bad < 0 && rep[i] !== expb[i]) bad = i;
        end
        if (bad >= 0) chk(1'b0, tag, $sformatf("reply byte %0d", bad),
                          int'(rep[bad]), int'(expb[bad]));
        else chk(1'b1, tag, "reply bytes", 0, 0);
    endtask

    task automatic run_txn(input bit rd, input logic [7:0] id, input logic [7:0] len,
                           input logic [31:0] a, input string tag);
        build_req(rd, id, len, a);
        predict(rd, id, len, a);
        rep_n = 0; rep_done = 1'b0;
        send_pkt();
        wait_reply();
        cmp_reply(tag);
        if (!rd) begin
            int bad;
            bad = 0;
            for (int i = 0; i < int'(len); i++)
                if (tmem[8'(a + 32'(i))] !== rmem[8'(a + 32'(i))]) bad++;
            // R4 target contents after the write burst
            chk(bad == 0, "R4", "target bytes differing", bad, 0);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic drop_case(input int kind);
        int act0, fr0;
        build_req(1'b1, 8'h5A, 8'd2, 32'h0000_0040);
        case (kind)
            0: pk[0] = 8'h7F;
            1: pk[1] = 8'h60;
            2: pk[1] = 8'h00;
            3: pk[3] = 8'd0;
            4: pk[3] = 8'(DEPTH + 1);
            5: begin pk[1] = 8'h20; pk[3] = 8'd4; pk[8] = 8'h11; pk[9] = 8'h22; pk_n = 10; end
            6: pk[1] = 8'hC0;
            default: pk_n = 5;
        endcase
        act0 = bus_act; fr0 = frames;
        rep_n = 0; rep_done = 1'b0;
        send_pkt();
        repeat (60) @(negedge clk);
        // R7 rejected packet: no bus traffic and no reply
        chk(bus_act == act0, "R7", $sformatf("bus cycles case %0d", kind), bus_act - act0, 0);
        chk(frames == fr0, "R7", $sformatf("replies case %0d", kind), frames - fr0, 0);
    endtask

    initial begin
        int fr0;
        void'($urandom(32'd7011));
        for (int i = 0; i < 256; i++) begin
            tmem[i] = 8'(i * 7 + 3);
            rmem[i] = 8'(i * 7 + 3);
        end
        rep_n = 0; frames = 0; bus_act = 0;
        rep_done = 1'b0; granted = 1'b0; in_frame = 1'b0;
        rst_n = 1'b0; rx_valid = 1'b0; rx_last = 1'b0; rx_data = 8'h00;
        repeat (3) @(negedge clk);
        // R1 outputs quiet under reset
        chk(!tx_req && !tx_valid && !bus_we && !bus_re, "R1", "outputs in reset",
            int'({tx_req, tx_valid, bus_we, bus_re}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_req && !tx_valid && !bus_we && !bus_re, "R1", "outputs after reset",
            int'({tx_req, tx_valid, bus_we, bus_re}), 0);

        run_txn(1'b1, 8'h11, 8'(DEPTH), 32'h1234_5600, "R2");
        run_txn(1'b0, 8'h22, 8'd1, 32'h0000_0030, "R4");
        run_txn(1'b0, 8'h23, 8'(DEPTH), 32'h0000_0080, "R5");
        run_txn(1'b0, 8'h33, 8'd4, 32'hABCD_00DE, "R6");
        run_txn(1'b1, 8'h44, 8'd3, 32'h0000_00E5, "R6");
        run_txn(1'b1, 8'h55, 8'd2, 32'h0000_00FF, "R3");

        for (int k = 0; k < 8; k++) drop_case(k);

        // R8 second packet arrives while the first is still on the bus
        build_req(1'b1, 8'h66, 8'd4, 32'h0000_00E0);
        predict(1'b1, 8'h66, 8'd4, 32'h0000_00E0);
        rep_n = 0; rep_done = 1'b0;
        fr0 = frames;
        send_pkt();
        build_req(1'b0, 8'h67, 8'd2, 32'h0000_0010);
        send_pkt();
        wait_reply();
        cmp_reply("R8");
        repeat (80) @(negedge clk);
        chk(frames == fr0 + 1, "R8", "replies for busy pair", frames - fr0, 1);
        chk(tmem[16] === rmem[16] && tmem[17] === rmem[17], "R8", "dropped write reached target",
            int'(tmem[16]), int'(rmem[16]));
        run_txn(1'b1, 8'h68, 8'd2, 32'h0000_0010, "R8");

        for (int t = 0; t < 40; t++) begin
            bit         rd;
            logic [7:0] len;
            logic [31:0] a;
            rd  = 1'($urandom_range(0, 1));
            len = 8'($urandom_range(1, DEPTH));
            a   = $urandom;
            run_txn(rd, 8'($urandom), len, a, rd ? "R2" : "R4");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule